// File: doc/BRIEF.md
# Banked Execution Priority and Fault Escalation Unit

This unit works out the running execution priority of a processor core that has two security states, Secure and Non-secure. It takes three kinds of input. The first is the two copies of each masking register: a base-priority threshold, a single-bit interrupt mask and a single-bit fault mask. The second is the group priority of the most urgent active exception. The third is two control bits. One control bit moves HardFault and NMI handling towards the Non-secure side. The other demotes the effect of Non-secure masks. The result is a signed priority, where a lower value is more urgent. The idle value is one step below the lowest configurable priority.

The same unit judges each synchronous fault request. A fault can preempt at its own group priority, or it must be escalated to HardFault. An escalated fault can still find the core already running at or above the urgency of the HardFault it would use, and in that case the core must enter lockup. The unit also drives the fixed priorities of Reset, NMI and the two HardFault banks, which move when the control bit moves.

Every output is registered and reflects the inputs present at the previous rising clock edge. Each fault verdict is held in a four-state register: IDLE means there is no fault request, PREEMPT means the fault runs at its own priority, ESCALATE means it goes to HardFault, and LOCKUP means HardFault cannot be taken. Every edge takes the register from its current state to the verdict for the present inputs. Any state can go to any state, and reset forces IDLE.

Top module: `epu_top`

## Requirements
- R1: While reset is asserted, the outputs are as follows. exec_prio_o is 256. escalate_o, lockup_o, hf_bank_s_o and hf_ns_enable_o are 0. The fixed priorities read −4 (Reset), −2 (NMI), −1 (Secure HardFault) and −1 (Non-secure HardFault).
- R2: The fixed priorities are Reset −4, NMI −2 and Non-secure HardFault −1. Secure HardFault is −3 when hf_to_ns_i is 1 and −1 when it is 0. hf_ns_enable_o equals hf_to_ns_i, so the Non-secure HardFault is never allowed to preempt while that bit is 0.
- R3: Every output changes only on a rising clock edge and shows the inputs sampled at that edge.
- R4: A nonzero base-priority value of either bank contributes its group priority, formed with that bank's own PRIGROUP. A zero value contributes nothing.
- R5: A set interrupt mask contributes priority 0. The one exception is a set Non-secure interrupt mask while demote_ns_i is 1, which contributes 0x80.
- R6: A set Non-secure fault mask contributes −1, or 0x80 while demote_ns_i is 1. A set Secure fault mask contributes −1, or −3 while hf_to_ns_i is 1.
- R7: exec_prio_o is the most urgent (signed minimum) of active_prio_i and every contribution. The contributions are applied in order: base priority, then interrupt mask, then fault mask. A less urgent contribution never raises the result.
- R8: The group priority of an 8-bit value keeps only the bits above bit position PRIGROUP. With PRIGROUP 7 it is 0. Negative values on active_prio_i pass through unmasked.
- R9: A fault request whose group priority is numerically lower than the execution priority preempts. Otherwise it escalates, and escalate_o is 1. The group priority uses the PRIGROUP of the fault's own bank.
- R10: The HardFault bank used is Secure (hf_bank_s_o = 1) when the fault is Secure or when hf_to_ns_i is 0. Otherwise it is Non-secure.
- R11: An escalated fault enters lockup (lockup_o = 1) when the execution priority is at or below the priority value of the chosen HardFault bank. Lockup always comes with escalate_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hf_to_ns_i | input | 1 | HardFault/NMI security selection control bit |
| demote_ns_i | input | 1 | Demote Non-secure masks control bit |
| basepri_s_i | input | 8 | Secure base-priority threshold, 0 = off |
| basepri_ns_i | input | 8 | Non-secure base-priority threshold, 0 = off |
| prigroup_s_i | input | 3 | Secure priority grouping split point |
| prigroup_ns_i | input | 3 | Non-secure priority grouping split point |
| primask_s_i | input | 1 | Secure interrupt mask |
| primask_ns_i | input | 1 | Non-secure interrupt mask |
| faultmask_s_i | input | 1 | Secure fault mask |
| faultmask_ns_i | input | 1 | Non-secure fault mask |
| active_prio_i | input | 10 | Signed group priority of the active exception, 256 when none |
| fault_req_i | input | 1 | Synchronous fault request |
| fault_is_s_i | input | 1 | Fault belongs to the Secure bank |
| fault_prio_i | input | 8 | Configured priority of the faulting exception |
| exec_prio_o | output | 10 | Signed execution priority |
| hf_bank_s_o | output | 1 | Chosen HardFault bank is Secure |
| escalate_o | output | 1 | Fault escalates to HardFault |
| lockup_o | output | 1 | Fault escalation enters lockup |
| prio_reset_o | output | 10 | Fixed Reset priority |
| prio_nmi_o | output | 10 | Fixed NMI priority |
| prio_hf_s_o | output | 10 | Secure HardFault priority |
| prio_hf_ns_o | output | 10 | Non-secure HardFault priority |
| hf_ns_enable_o | output | 1 | Non-secure HardFault may preempt |

## Verification
The bench builds the unit with the default 8-bit priority width. This gives the 10-bit signed range. The idle value is 256 and the demoted value is 0x80. The bench applies PRIGROUP values from 0 to 7, so the masking reaches the case where the whole priority becomes subpriority. It also reaches cases where Secure and Non-secure grouping differ, so the result depends on using the fault's own bank. Escalation cases include a fault priority equal to the execution priority, a case where group and full priority give opposite verdicts, and every pairing of fault-mask bank with HardFault bank that sits on the lockup boundary.

// File: rtl/epu_pkg.sv
`timescale 1ns/1ps
package epu_pkg;

    // Verdict held for the most recent fault request.
    typedef enum logic [1:0] {
        DEC_IDLE     = 2'd0,
        DEC_PREEMPT  = 2'd1,
        DEC_ESCALATE = 2'd2,
        DEC_LOCKUP   = 2'd3
    } dec_state_e;

    // Fixed negative priorities (sign-extended by users).
    localparam int FIX_RESET    = -4;
    localparam int FIX_HF_S_HI  = -3;
    localparam int FIX_NMI      = -2;
    localparam int FIX_HF_LOW   = -1;

endpackage

// File: rtl/epu_group_mask.sv
`timescale 1ns/1ps
// Keeps only the bits of a priority that lie above the grouping split point.
module epu_group_mask #(
    parameter int PRIO_BITS = 8,
    localparam int PGW      = $clog2(PRIO_BITS)
) (
    input  logic [PRIO_BITS-1:0] raw_i,
    input  logic [PGW-1:0]       split_i,
    output logic [PRIO_BITS-1:0] grp_o
);
    logic [PRIO_BITS:0] keep;

    always_comb begin
        keep  = {(PRIO_BITS+1){1'b1}} << (int'(split_i) + 1);
        grp_o = raw_i & keep[PRIO_BITS-1:0];
    end
endmodule

// File: rtl/epu_fixed_prio.sv
`timescale 1ns/1ps
// Fixed priorities of Reset, NMI and both HardFault banks.
module epu_fixed_prio
    import epu_pkg::*;
#(
    parameter int PW = 10
) (
    input  logic                 hf_to_ns_i,
    output logic signed [PW-1:0] reset_p_o,
    output logic signed [PW-1:0] nmi_p_o,
    output logic signed [PW-1:0] hf_s_p_o,
    output logic signed [PW-1:0] hf_ns_p_o,
    output logic                 hf_ns_en_o
);
    always_comb begin
        reset_p_o  = PW'(FIX_RESET);
        nmi_p_o    = PW'(FIX_NMI);
        hf_ns_p_o  = PW'(FIX_HF_LOW);
        hf_s_p_o   = hf_to_ns_i ? PW'(FIX_HF_S_HI) : PW'(FIX_HF_LOW);
        // Non-secure HardFault may pend but never preempt while the bit is 0.
        hf_ns_en_o = hf_to_ns_i;
    end
endmodule

// File: rtl/epu_mask_chain.sv
`timescale 1ns/1ps
// Applies base priority, interrupt mask and fault mask in order, each one
// lowering the running value only when its own result is more urgent.
module epu_mask_chain
    import epu_pkg::*;
#(
    parameter int PRIO_BITS = 8,
    localparam int PW       = PRIO_BITS + 2
) (
    input  logic signed [PW-1:0]  active_i,
    input  logic [PRIO_BITS-1:0]  bp_s_raw_i,
    input  logic [PRIO_BITS-1:0]  bp_ns_raw_i,
    input  logic [PRIO_BITS-1:0]  bp_s_grp_i,
    input  logic [PRIO_BITS-1:0]  bp_ns_grp_i,
    input  logic                  pm_s_i,
    input  logic                  pm_ns_i,
    input  logic                  fm_s_i,
    input  logic                  fm_ns_i,
    input  logic                  demote_i,
    input  logic                  hf_to_ns_i,
    output logic signed [PW-1:0]  exec_o
);
    localparam logic signed [PW-1:0] P_ZERO  = '0;
    localparam logic signed [PW-1:0] P_HALF  = PW'(2 ** (PRIO_BITS - 1));
    localparam logic signed [PW-1:0] P_NEG1  = PW'(FIX_HF_LOW);
    localparam logic signed [PW-1:0] P_NEG3  = PW'(FIX_HF_S_HI);

    localparam int NSTAGE = 6;

    logic signed [PW-1:0] cand  [NSTAGE];
    logic                 valid [NSTAGE];
    logic signed [PW-1:0] run   [NSTAGE+1];

    always_comb begin
        // Stage order: base priority NS, S; interrupt mask NS, S; fault mask NS, S.
        cand[0]  = $signed({2'b00, bp_ns_grp_i});
        valid[0] = |bp_ns_raw_i;
        cand[1]  = $signed({2'b00, bp_s_grp_i});
        valid[1] = |bp_s_raw_i;
        cand[2]  = demote_i ? P_HALF : P_ZERO;
        valid[2] = pm_ns_i;
        cand[3]  = P_ZERO;
        valid[3] = pm_s_i;
        cand[4]  = demote_i ? P_HALF : P_NEG1;
        valid[4] = fm_ns_i;
        cand[5]  = hf_to_ns_i ? P_NEG3 : P_NEG1;
        valid[5] = fm_s_i;
    end

    assign run[0] = active_i;

    generate
        for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
            assign run[g+1] = (valid[g] && (cand[g] < run[g])) ? cand[g] : run[g];
        end
    endgenerate

    assign exec_o = run[NSTAGE];
endmodule

// File: rtl/epu_escalate.sv
`timescale 1ns/1ps
// Decides preempt / escalate / lockup for a fault request.
module epu_escalate
    import epu_pkg::*;
#(
    parameter int PRIO_BITS = 8,
    localparam int PW       = PRIO_BITS + 2
) (
    input  logic                  fault_req_i,
    input  logic                  fault_is_s_i,
    input  logic [PRIO_BITS-1:0]  fault_grp_i,
    input  logic signed [PW-1:0]  exec_i,
    input  logic                  hf_to_ns_i,
    input  logic signed [PW-1:0]  hf_s_p_i,
    input  logic signed [PW-1:0]  hf_ns_p_i,
    output dec_state_e            verdict_o,
    output logic                  bank_s_o
);
    logic signed [PW-1:0] gp;
    logic signed [PW-1:0] hf_p;

    always_comb begin
        gp       = $signed({2'b00, fault_grp_i});
        bank_s_o = fault_is_s_i || !hf_to_ns_i;
        hf_p     = bank_s_o ? hf_s_p_i : hf_ns_p_i;
        if (!fault_req_i) begin
            verdict_o = DEC_IDLE;
        end else if (gp < exec_i) begin
            verdict_o = DEC_PREEMPT;
        end else if (exec_i <= hf_p) begin
            verdict_o = DEC_LOCKUP;
        end else begin
            verdict_o = DEC_ESCALATE;
        end
    end
endmodule

// File: rtl/epu_top.sv
`timescale 1ns/1ps
module epu_top
    import epu_pkg::*;
#(
    parameter int PRIO_BITS = 8,
    localparam int PGW      = $clog2(PRIO_BITS),
    localparam int PW       = PRIO_BITS + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hf_to_ns_i,
    input  logic                  demote_ns_i,
    input  logic [PRIO_BITS-1:0]  basepri_s_i,
    input  logic [PRIO_BITS-1:0]  basepri_ns_i,
    input  logic [PGW-1:0]        prigroup_s_i,
    input  logic [PGW-1:0]        prigroup_ns_i,
    input  logic                  primask_s_i,
    input  logic                  primask_ns_i,
    input  logic                  faultmask_s_i,
    input  logic                  faultmask_ns_i,
    input  logic signed [PW-1:0]  active_prio_i,
    input  logic                  fault_req_i,
    input  logic                  fault_is_s_i,
    input  logic [PRIO_BITS-1:0]  fault_prio_i,
    output logic signed [PW-1:0]  exec_prio_o,
    output logic                  hf_bank_s_o,
    output logic                  escalate_o,
    output logic                  lockup_o,
    output logic signed [PW-1:0]  prio_reset_o,
    output logic signed [PW-1:0]  prio_nmi_o,
    output logic signed [PW-1:0]  prio_hf_s_o,
    output logic signed [PW-1:0]  prio_hf_ns_o,
    output logic                  hf_ns_enable_o
);
    localparam logic signed [PW-1:0] P_IDLE = PW'(2 ** PRIO_BITS);
    localparam int NSRC = 3;  // base priority S, base priority NS, fault

    // Group priorities of the three sources, each with its own bank split.
    logic [PRIO_BITS-1:0] src_raw [NSRC];
    logic [PGW-1:0]       src_pg  [NSRC];
    logic [PRIO_BITS-1:0] src_grp [NSRC];

    always_comb begin
        src_raw[0] = basepri_s_i;
        src_pg[0]  = prigroup_s_i;
        src_raw[1] = basepri_ns_i;
        src_pg[1]  = prigroup_ns_i;
        src_raw[2] = fault_prio_i;
        src_pg[2]  = fault_is_s_i ? prigroup_s_i : prigroup_ns_i;
    end

    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_grp
            epu_group_mask #(.PRIO_BITS(PRIO_BITS)) u_gm (
                .raw_i   (src_raw[s]),
                .split_i (src_pg[s]),
                .grp_o   (src_grp[s])
            );
        end
    endgenerate

    logic signed [PW-1:0] fx_reset, fx_nmi, fx_hf_s, fx_hf_ns;
    logic                 fx_ns_en;

    epu_fixed_prio #(.PW(PW)) u_fixed (
        .hf_to_ns_i (hf_to_ns_i),
        .reset_p_o  (fx_reset),
        .nmi_p_o    (fx_nmi),
        .hf_s_p_o   (fx_hf_s),
        .hf_ns_p_o  (fx_hf_ns),
        .hf_ns_en_o (fx_ns_en)
    );

    logic signed [PW-1:0] exec_d;

    epu_mask_chain #(.PRIO_BITS(PRIO_BITS)) u_chain (
        .active_i    (active_prio_i),
        .bp_s_raw_i  (basepri_s_i),
        .bp_ns_raw_i (basepri_ns_i),
        .bp_s_grp_i  (src_grp[0]),
        .bp_ns_grp_i (src_grp[1]),
        .pm_s_i      (primask_s_i),
        .pm_ns_i     (primask_ns_i),
        .fm_s_i      (faultmask_s_i),
        .fm_ns_i     (faultmask_ns_i),
        .demote_i    (demote_ns_i),
        .hf_to_ns_i  (hf_to_ns_i),
        .exec_o      (exec_d)
    );

    dec_state_e state_d, state_q;
    logic       bank_d;

    epu_escalate #(.PRIO_BITS(PRIO_BITS)) u_esc (
        .fault_req_i  (fault_req_i),
        .fault_is_s_i (fault_is_s_i),
        .fault_grp_i  (src_grp[2]),
        .exec_i       (exec_d),
        .hf_to_ns_i   (hf_to_ns_i),
        .hf_s_p_i     (fx_hf_s),
        .hf_ns_p_i    (fx_hf_ns),
        .verdict_o    (state_d),
        .bank_s_o     (bank_d)
    );

    // State register: fault verdict.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DEC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Data registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exec_prio_o    <= P_IDLE;
            hf_bank_s_o    <= 1'b0;
            prio_reset_o   <= PW'(FIX_RESET);
            prio_nmi_o     <= PW'(FIX_NMI);
            prio_hf_s_o    <= PW'(FIX_HF_LOW);
            prio_hf_ns_o   <= PW'(FIX_HF_LOW);
            hf_ns_enable_o <= 1'b0;
        end else begin
            exec_prio_o    <= exec_d;
            hf_bank_s_o    <= bank_d;
            prio_reset_o   <= fx_reset;
            prio_nmi_o     <= fx_nmi;
            prio_hf_s_o    <= fx_hf_s;
            prio_hf_ns_o   <= fx_hf_ns;
            hf_ns_enable_o <= fx_ns_en;
        end
    end

    // Output decode of the verdict state.
    always_comb begin
        unique case (state_q)
            DEC_IDLE:     begin escalate_o = 1'b0; lockup_o = 1'b0; end
            DEC_PREEMPT:  begin escalate_o = 1'b0; lockup_o = 1'b0; end
            DEC_ESCALATE: begin escalate_o = 1'b1; lockup_o = 1'b0; end
            DEC_LOCKUP:   begin escalate_o = 1'b1; lockup_o = 1'b1; end
        endcase
    end
endmodule

// File: rtl/epu_chk.sv
`timescale 1ns/1ps
module epu_chk #(
    parameter int PRIO_BITS = 8,
    localparam int PW       = PRIO_BITS + 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 fault_req_i,
    input logic                 faultmask_ns_i,
    input logic                 demote_ns_i,
    input logic signed [PW-1:0] exec_prio_o,
    input logic                 hf_bank_s_o,
    input logic                 escalate_o,
    input logic                 lockup_o,
    input logic signed [PW-1:0] prio_reset_o,
    input logic signed [PW-1:0] prio_nmi_o,
    input logic signed [PW-1:0] prio_hf_s_o,
    input logic signed [PW-1:0] prio_hf_ns_o,
    input logic                 hf_ns_enable_o
);
    localparam logic signed [PW-1:0] C_IDLE = PW'(2 ** PRIO_BITS);
    localparam logic signed [PW-1:0] C_NEG1 = PW'(-1);
    localparam logic signed [PW-1:0] C_NEG3 = PW'(-3);

    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_fixed_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_reset_o < prio_hf_s_o) && (prio_nmi_o < prio_hf_ns_o));

    p_hf_s_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prio_hf_s_o == (hf_ns_enable_o ? C_NEG3 : C_NEG1));

    p_lockup_is_escalate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lockup_o |-> escalate_o);

    p_no_fault_no_escalate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(fault_req_i)) |-> !escalate_o);

    p_fm_ns_urgent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(faultmask_ns_i && !demote_ns_i)) |-> (exec_prio_o <= C_NEG1));

    p_exec_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_prio_o <= C_IDLE) && (exec_prio_o >= C_NEG3));

    p_ns_lockup_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lockup_o && !hf_bank_s_o) |-> (exec_prio_o <= C_NEG1));
endmodule

bind epu_top epu_chk #(.PRIO_BITS(PRIO_BITS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fault_req_i    (fault_req_i),
    .faultmask_ns_i (faultmask_ns_i),
    .demote_ns_i    (demote_ns_i),
    .exec_prio_o    (exec_prio_o),
    .hf_bank_s_o    (hf_bank_s_o),
    .escalate_o     (escalate_o),
    .lockup_o       (lockup_o),
    .prio_reset_o   (prio_reset_o),
    .prio_nmi_o     (prio_nmi_o),
    .prio_hf_s_o    (prio_hf_s_o),
    .prio_hf_ns_o   (prio_hf_ns_o),
    .hf_ns_enable_o (hf_ns_enable_o)
);

// File: tb/epu_top_tb_top.sv
`timescale 1ns/1ps
module epu_top_tb_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hf_to_ns_i = 1'b0, demote_ns_i = 1'b0;
    logic [7:0]        basepri_s_i = '0, basepri_ns_i = '0;
    logic [2:0]        prigroup_s_i = '0, prigroup_ns_i = '0;
    logic              primask_s_i = 1'b0, primask_ns_i = 1'b0;
    logic              faultmask_s_i = 1'b0, faultmask_ns_i = 1'b0;
    logic signed [9:0] active_prio_i = 10'sd256;
    logic              fault_req_i = 1'b0, fault_is_s_i = 1'b0;
    logic [7:0]        fault_prio_i = '0;
    logic signed [9:0] exec_prio_o, prio_reset_o, prio_nmi_o, prio_hf_s_o, prio_hf_ns_o;
    logic              hf_bank_s_o, escalate_o, lockup_o, hf_ns_enable_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    epu_top dut_i (
        .clk(clk), .rst_n(rst_n), .hf_to_ns_i(hf_to_ns_i), .demote_ns_i(demote_ns_i),
        .basepri_s_i(basepri_s_i), .basepri_ns_i(basepri_ns_i),
        .prigroup_s_i(prigroup_s_i), .prigroup_ns_i(prigroup_ns_i),
        .primask_s_i(primask_s_i), .primask_ns_i(primask_ns_i),
        .faultmask_s_i(faultmask_s_i), .faultmask_ns_i(faultmask_ns_i),
        .active_prio_i(active_prio_i), .fault_req_i(fault_req_i),
        .fault_is_s_i(fault_is_s_i), .fault_prio_i(fault_prio_i),
        .exec_prio_o(exec_prio_o), .hf_bank_s_o(hf_bank_s_o),
        .escalate_o(escalate_o), .lockup_o(lockup_o),
        .prio_reset_o(prio_reset_o), .prio_nmi_o(prio_nmi_o),
        .prio_hf_s_o(prio_hf_s_o), .prio_hf_ns_o(prio_hf_ns_o),
        .hf_ns_enable_o(hf_ns_enable_o)
    );

    typedef struct packed {
        logic [7:0]        bs;
        logic [7:0]        bn;
        logic [2:0]        pgs;
        logic [2:0]        pgn;
        logic              pms;
        logic              pmn;
        logic              fms;
        logic              fmn;
        logic              dem;
        logic              hfn;
        logic signed [9:0] act;
        logic signed [9:0] exp;
    } vec_t;

    localparam int NV = 17;
    //                      bs     bn     pgs   pgn   pms   pmn   fms   fmn   dem   hfn   act        exp
    localparam vec_t VEC [NV] = '{
        '{8'h00, 8'h00, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'sd256, 10'sd256}, // R7 idle
        '{8'h00, 8'h40, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'sd256, 10'sd64},  // R4 NS basepri
        '{8'h35, 8'h00, 3'd4, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'sd256, 10'sd32},  // R8 split 4
        '{8'h00, 8'h35, 3'd0, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'sd256, 10'sd32},  // R4 own bank split
        '{8'h00, 8'h00, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 10'sd256, 10'sd0},   // R5 NS primask
        '{8'h00, 8'h00, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 10'sd256, 10'sd128}, // R5 demoted
        '{8'h40, 8'h00, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 10'sd256, 10'sd64},  // R7 S basepri wins
        '{8'hC0, 8'h00, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 10'sd256, 10'sd128}, // R7 demoted wins
        '{8'h00, 8'h00, 3'd0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 10'sd256, 10'sd0},   // R5 S primask
        '{8'h00, 8'h00, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 10'sd256, -10'sd1},  // R6 NS faultmask
        '{8'h00, 8'h00, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'sd256, 10'sd128}, // R6 NS demoted
        '{8'h00, 8'h00, 3'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 10'sd256, -10'sd1},  // R6 S fm bit 0
        '{8'h00, 8'h00, 3'd0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 10'sd256, -10'sd3},  // R6 S fm bit 1
        '{8'h00, 8'h60, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'sd16,  10'sd16},  // R7 active wins
        '{8'h00, 8'h00, 3'd7, 3'd7, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, -10'sd2,  -10'sd2},  // R8 negative unmasked
        '{8'h90, 8'h00, 3'd7, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'sd256, 10'sd0},   // R8 split 7
        '{8'h00, 8'h00, 3'd0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 10'sd256, 10'sd0}    // R7 order
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put_vec(input vec_t v);
        basepri_s_i    = v.bs;
        basepri_ns_i   = v.bn;
        prigroup_s_i   = v.pgs;
        prigroup_ns_i  = v.pgn;
        primask_s_i    = v.pms;
        primask_ns_i   = v.pmn;
        faultmask_s_i  = v.fms;
        faultmask_ns_i = v.fmn;
        demote_ns_i    = v.dem;
        hf_to_ns_i     = v.hfn;
        active_prio_i  = v.act;
    endtask

    task automatic clear_all();
        put_vec('{8'h00, 8'h00, 3'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'sd256, 10'sd256});
        fault_req_i  = 1'b0;
        fault_is_s_i = 1'b0;
        fault_prio_i = 8'h00;
    endtask

    // Drive a fault on a negedge, sample the registered verdict one cycle later.
    task automatic fault_case(input string req, input logic is_s, input logic [7:0] fp,
                              input int exp_esc, input int exp_lock, input int exp_bank);
        @(negedge clk);
        fault_req_i  = 1'b1;
        fault_is_s_i = is_s;
        fault_prio_i = fp;
        @(negedge clk);
        check({req, " escalate"}, int'(escalate_o), exp_esc);
        check({req, " lockup"},   int'(lockup_o),   exp_lock);
        check({req, " bank"},     int'(hf_bank_s_o), exp_bank);
        fault_req_i = 1'b0;
    endtask

    initial begin
        // R1: reset values while reset is held, with inputs that would change them
        primask_s_i   = 1'b1;
        hf_to_ns_i    = 1'b1;
        fault_req_i   = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 exec", int'(exec_prio_o), 256);
        check("R1 escalate", int'(escalate_o), 0);
        check("R1 lockup", int'(lockup_o), 0);
        check("R1 hf_ns_enable", int'(hf_ns_enable_o), 0);
        check("R1 reset prio", int'(prio_reset_o), -4);
        check("R1 hf_s prio", int'(prio_hf_s_o), -1);
        clear_all();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk (R4..R8)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            put_vec(VEC[i]);
            @(negedge clk);
            check($sformatf("R7 vector %0d exec", i), int'(exec_prio_o), int'(VEC[i].exp));
        end

        // R3: output holds until the next rising edge
        @(negedge clk);
        clear_all();
        @(negedge clk);
        primask_s_i = 1'b1;
        #1;
        check("R3 before edge", int'(exec_prio_o), 256);
        @(negedge clk);
        check("R3 after edge", int'(exec_prio_o), 0);

        // R2: fixed priorities for both control-bit settings
        clear_all();
        @(negedge clk);
        check("R2 reset", int'(prio_reset_o), -4);
        check("R2 nmi", int'(prio_nmi_o), -2);
        check("R2 hf_s bit0", int'(prio_hf_s_o), -1);
        check("R2 hf_ns", int'(prio_hf_ns_o), -1);
        check("R2 ns enable bit0", int'(hf_ns_enable_o), 0);
        hf_to_ns_i = 1'b1;
        @(negedge clk);
        check("R2 hf_s bit1", int'(prio_hf_s_o), -3);
        check("R2 ns enable bit1", int'(hf_ns_enable_o), 1);
        check("R2 nmi bit1", int'(prio_nmi_o), -2);

        // R9: idle core, fault preempts
        clear_all();
        fault_case("R9 idle", 1'b0, 8'h20, 0, 0, 1);
        // R9: equal priority escalates; R10 bank is Secure with bit 0
        clear_all();
        basepri_ns_i = 8'h20;
        fault_case("R9 equal", 1'b0, 8'h20, 1, 0, 1);
        // R9: group (not full) priority, fault's own bank split
        clear_all();
        active_prio_i = 10'sd33;
        prigroup_s_i  = 3'd2;
        fault_case("R9 group S", 1'b1, 8'h23, 0, 0, 1);
        fault_case("R9 group NS", 1'b0, 8'h23, 1, 0, 1);
        // R11: NS faultmask, NS HardFault bank -> lockup; R10 bank NS
        clear_all();
        hf_to_ns_i     = 1'b1;
        faultmask_ns_i = 1'b1;
        fault_case("R11 ns bank", 1'b0, 8'h10, 1, 1, 0);
        // R10: Secure fault uses Secure HardFault at -3, no lockup
        fault_case("R10 s bank", 1'b1, 8'h10, 1, 0, 1);
        // R11: Secure faultmask at -3 locks a Secure fault
        clear_all();
        hf_to_ns_i    = 1'b1;
        faultmask_s_i = 1'b1;
        fault_case("R11 s fm", 1'b1, 8'h10, 1, 1, 1);
        // R10/R11: bit 0 forces Secure bank at -1, NS faultmask -> lockup
        clear_all();
        faultmask_ns_i = 1'b1;
        fault_case("R10 forced s", 1'b0, 8'h10, 1, 1, 1);
        // R9: verdict returns to idle after request drops
        @(negedge clk);
        check("R9 release", int'(escalate_o), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule